// File: doc/BRIEF.md
# Square-Wave Phase Comparator with Duty-Cycle Measurement

This block compares the phase of two square waves for a synthesizer loop. A reference square wave, much slower than the system clock but faster than the comparison rate, is first divided by a parameter ratio (100 by default) to give a 50 % duty comparison wave. The divided wave and a feedback square wave of the same frequency are then exclusive-ORed. The XOR bit goes straight out. The number of system-clock cycles in which it is high over one comparison period is measured and presented as an error word.

Because the XOR high time grows linearly with the phase offset between the two waves, the error word is zero when the waves are in phase. It reaches the period length, counted in system clocks, when they are opposite. A quarter-period offset gives half of that, which is the normal lock point. A complementary word, which counts the XOR low time, serves a loop stage that needs the opposite sense. Each new pair of words is announced by a one-cycle strobe.

Top module: `phdet_xor_pd`

## Requirements
- R1: While reset is high and in the cycle after it, `valid_o` is 0 and both `err_o` and `err_inv_o` are 0.
- R2: After reset the divided reference is low. It toggles on every DIV/2-th rising edge of `ref_in`, so one comparison period spans DIV reference periods. With a reference of 4 clocks and DIV=100 this is 400 clocks, and the first divided rising edge comes from the 50th reference rising edge.
- R3: Both inputs pass through SYNC_STAGES flops. The feedback gets one more flop, so that the feedback and the divided reference reach the XOR with the same delay (three clocks by default).
- R4: With the two waves in phase, `err_o` is 0 and `xor_o` stays 0.
- R5: With the two waves half a period apart, `err_o` equals the period in clocks and `xor_o` stays 1.
- R6: For an offset of e clocks on a period of P clocks, `err_o` = 2·min(e, P−e). This is linear, and a quarter-period offset gives P/2.
- R7: With INV_EN=1, `err_inv_o` counts the XOR low cycles of the same period, which is P − `err_o`. With INV_EN=0 it is always 0.
- R8: `valid_o` is a one-cycle pulse issued once for each divided-reference rising edge, so strobes are P clocks apart. The first strobe comes only at the second divided rising edge, after one full period has been measured.
- R9: `err_o` and `err_inv_o` change only in a cycle where `valid_o` is high, and hold their values between strobes.
- R10: Each count saturates at 2^ERR_W − 1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference square wave, divided inside |
| fb_in | input | 1 | Feedback square wave at the comparison rate |
| xor_o | output | 1 | Raw XOR of the aligned divided reference and feedback |
| err_o | output | ERR_W | XOR high-cycle count of the last full period |
| err_inv_o | output | ERR_W | XOR low-cycle count of the last full period (0 when INV_EN=0) |
| valid_o | output | 1 | One-cycle strobe when the error words are updated |

## Verification
The feedback is driven in step with the reference, at a chosen offset from the ideal divided wave. The offsets used are in phase, opposite, a quarter and three quarters of a period, one clock either side of zero, and random values. In phase tells a correct delay match from a one-clock skew, which would show up as a count of 2. Opposite phase shows that the full period is counted. The quarter offsets confirm the midscale lock point and the symmetry about half a period. A second instance with a narrow word and no inverted output exposes saturation and the disabled complement. The spacing and timing of strobes, and the holding of the words between strobes, are checked at every offset.

// File: rtl/phdet_pkg.sv
package phdet_pkg;

    // default depth of the input synchronizers
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // level and one-cycle rising-edge marker of a square wave inside the clock domain
    typedef struct packed {
        logic lvl;
        logic rise;
    } sq_t;

    // counter width needed to count 0 .. n-1, never below one bit
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/phdet_sync.sv
module phdet_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/phdet_refdiv.sv
module phdet_refdiv
    import phdet_pkg::*;
#(
    parameter int unsigned DIV = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_s,
    output sq_t  dref
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned CW   = cnt_bits(HALF);

    logic          ref_q;
    logic [CW-1:0] cnt;
    logic          lvl;
    logic          lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            cnt   <= '0;
            lvl   <= 1'b0;
            lvl_q <= 1'b0;
        end else begin
            ref_q <= ref_s;
            lvl_q <= lvl;
            if (ref_s && !ref_q) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    lvl <= ~lvl;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign dref.lvl  = lvl;
    assign dref.rise = lvl & ~lvl_q;
endmodule

// File: rtl/phdet_meter.sv
module phdet_meter
    import phdet_pkg::*;
#(
    parameter int unsigned ERR_W  = 10,
    parameter bit          INV_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  sq_t              dref,
    input  logic             xor_b,
    output logic [ERR_W-1:0] err_hi,
    output logic [ERR_W-1:0] err_lo,
    output logic             valid
);
    localparam logic [ERR_W-1:0] MAXV = '1;
    localparam logic [ERR_W-1:0] ONE  = ERR_W'(1);

    logic [ERR_W-1:0] hi_cnt;
    logic             armed;

    // high-time counter, latch and strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            err_hi <= '0;
            armed  <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (dref.rise) begin
                if (armed) err_hi <= hi_cnt;
                valid  <= armed;
                armed  <= 1'b1;
                hi_cnt <= xor_b ? ONE : '0;
            end else if (xor_b && hi_cnt != MAXV) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    generate
        if (INV_EN) begin : g_inv
            logic [ERR_W-1:0] lo_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_cnt <= '0;
                    err_lo <= '0;
                end else if (dref.rise) begin
                    if (armed) err_lo <= lo_cnt;
                    lo_cnt <= xor_b ? '0 : ONE;
                end else if (!xor_b && lo_cnt != MAXV) begin
                    lo_cnt <= lo_cnt + 1'b1;
                end
            end
        end else begin : g_noinv
            assign err_lo = '0;
        end
    endgenerate
endmodule

// File: rtl/phdet_xor_pd.sv
module phdet_xor_pd
    import phdet_pkg::*;
#(
    parameter int unsigned DIV         = 100,
    parameter int unsigned ERR_W       = 10,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter bit          INV_EN      = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic             xor_o,
    output logic [ERR_W-1:0] err_o,
    output logic [ERR_W-1:0] err_inv_o,
    output logic             valid_o
);
    logic ref_s;
    logic fb_s;
    logic fb_al;
    sq_t  dref;

    phdet_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst(rst), .d(ref_in), .q(ref_s)
    );

    phdet_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst(rst), .d(fb_in), .q(fb_s)
    );

    // matches the edge-detect plus toggle register of the divider path
    always_ff @(posedge clk) begin
        if (rst) fb_al <= 1'b0;
        else     fb_al <= fb_s;
    end

    phdet_refdiv #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .ref_s(ref_s), .dref(dref)
    );

    assign xor_o = dref.lvl ^ fb_al;

    phdet_meter #(.ERR_W(ERR_W), .INV_EN(INV_EN)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .dref   (dref),
        .xor_b  (xor_o),
        .err_hi (err_o),
        .err_lo (err_inv_o),
        .valid  (valid_o)
    );
endmodule

// File: rtl/phdet_xor_pd_chk.sv
module phdet_xor_pd_chk #(
    parameter int unsigned ERR_W  = 10,
    parameter bit          INV_EN = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_o,
    input logic [ERR_W-1:0] err_o,
    input logic [ERR_W-1:0] err_inv_o
);
    localparam logic [ERR_W-1:0] MAXV = '1;

    logic [31:0] gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (valid_o) begin
            gap  <= 32'd1;
            seen <= 1'b1;
        end else begin
            gap <= gap + 32'd1;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);  // R8

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(err_o) && $stable(err_inv_o)));  // R9

    AST_HI_BOUND: assert property (@(posedge clk) disable iff (rst)
        (valid_o && seen) |-> (32'(err_o) <= gap));  // R6

    generate
        if (INV_EN) begin : g_sum
            AST_SUM_PERIOD: assert property (@(posedge clk) disable iff (rst)
                (valid_o && seen && err_o != MAXV && err_inv_o != MAXV)
                |-> (32'(err_o) + 32'(err_inv_o) == gap));  // R7
        end
    endgenerate
endmodule

bind phdet_xor_pd phdet_xor_pd_chk #(.ERR_W(ERR_W), .INV_EN(INV_EN)) u_chk (
    .clk(clk), .rst(rst), .valid_o(valid_o), .err_o(err_o), .err_inv_o(err_inv_o)
);

// File: tb/phdet_xor_pd_test.sv
module phdet_xor_pd_test;
    localparam int DIV   = 100;
    localparam int RPER  = 4;               // reference period in clocks
    localparam int P     = DIV * RPER;      // comparison period in clocks
    localparam int T0    = RPER * (DIV / 2 - 1); // first divided rise, in drive steps
    localparam int ERR_W = 10;
    localparam int SAT_W = 8;
    localparam int SMAX  = (1 << SAT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;

    logic             xor_o, valid_o;
    logic [ERR_W-1:0] err_o, err_inv_o;
    logic             s_xor, s_valid;
    logic [SAT_W-1:0] s_err, s_inv;

    always #10 clk = ~clk;   // 50 MHz

    phdet_xor_pd #(.DIV(DIV), .ERR_W(ERR_W), .INV_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .xor_o(xor_o), .err_o(err_o), .err_inv_o(err_inv_o), .valid_o(valid_o)
    );

    phdet_xor_pd #(.DIV(DIV), .ERR_W(SAT_W), .INV_EN(1'b0)) uut_sat (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .xor_o(s_xor), .err_o(s_err), .err_inv_o(s_inv), .valid_o(s_valid)
    );

    int checks = 0;
    int fails  = 0;
    int t      = 0;
    int e      = 0;
    int cyc    = 0;
    bit run    = 1'b0;

    int c_hi, c_lo, c_shi, c_slo, c_cyc;

    function automatic logic fb_wave(input int tt, input int ee);
        return logic'(((tt + 10 * P - T0 - ee) % P) < (P / 2));
    endfunction

    function automatic int exp_hi(input int ee);
        return (ee < P - ee) ? 2 * ee : 2 * (P - ee);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!valid_o);
        c_hi  = int'(err_o);
        c_lo  = int'(err_inv_o);
        c_shi = int'(s_err);
        c_slo = int'(s_inv);
        c_cyc = cyc;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // stimulus driver: both waves derived from one step counter
    initial begin
        forever begin
            @(negedge clk);
            if (run) begin
                ref_in = logic'((t % RPER) < (RPER / 2));
                fb_in  = fb_wave(t, e);
                t++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic run_phase(input int ph, input bit count_xor);
        int prev, hi, n;
        e = ph;
        wait_valid();
        wait_valid();
        prev = c_cyc;
        wait_valid();
        hi = exp_hi(ph);
        chk(c_hi == hi, "R6 err_o vs offset", c_hi, hi);
        chk(c_lo == P - hi, "R7 inverted word", c_lo, P - hi);
        chk(c_shi == ((hi > SMAX) ? SMAX : hi), "R10 saturated word", c_shi,
            (hi > SMAX) ? SMAX : hi);
        chk(c_slo == 0, "R7 disabled inverted word", c_slo, 0);
        chk(c_cyc - prev == P, "R8 R2 strobe spacing", c_cyc - prev, P);
        repeat (P / 2) @(negedge clk);
        chk(int'(err_o) == c_hi && !valid_o, "R9 hold between strobes", int'(err_o), c_hi);
        if (count_xor) begin
            n = 0;
            for (int k = 0; k < P; k++) begin
                @(negedge clk);
                if (xor_o) n++;
            end
            chk(n == hi, "R3 R4 R5 raw xor high cycles", n, hi);
        end
    endtask

    initial begin
        int first_t;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(!valid_o && err_o == 0 && err_inv_o == 0, "R1 reset state",
            int'(valid_o) + int'(err_o) + int'(err_inv_o), 0);
        rst = 1'b0;
        run = 1'b1;
        @(negedge clk);
        chk(!valid_o && err_o == 0 && err_inv_o == 0, "R1 after reset",
            int'(valid_o) + int'(err_o) + int'(err_inv_o), 0);

        // first strobe only after the second divided rising edge (step T0 + P)
        e = 0;
        wait_valid();
        first_t = t;
        chk(first_t >= T0 + P && first_t <= T0 + P + 10, "R8 R2 first strobe step",
            first_t, T0 + P);
        chk(c_hi == 0, "R4 R3 first period in phase", c_hi, 0);

        run_phase(0, 1'b1);          // R4 in phase
        run_phase(P / 2, 1'b1);      // R5 opposite
        run_phase(P / 4, 1'b1);      // R6 midscale
        run_phase(3 * P / 4, 1'b1);  // R6 symmetry
        run_phase(1, 1'b0);          // R3 one clock late
        run_phase(P - 1, 1'b0);      // R3 one clock early
        for (int i = 0; i < 8; i++) begin
            run_phase(int'($urandom % (P + 1)), (i % 2) == 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule